// File: doc/BRIEF.md
# Operand-Handshake Computation Unit Manager

This block sits between an issue stage and an arithmetic unit that may take zero or more cycles to produce its answer. It accepts an operation record on a one-cycle issue strobe, stays busy until the operation is fully retired, and controls every data movement in between. Each source operand is fetched through its own release/go handshake, and the unit then hands the captured operands to the arithmetic unit over a valid/ready pair. The answers are written back through a second set of per-port release/go handshakes.

Operand fetches can be skipped in three ways. A live skip mask, held by the issuer while busy is high, suppresses any source port. A zero flag replaces source A with zero. An immediate flag replaces source B with the supplied constant. On the output side, a per-result ok flag from the arithmetic unit decides which result ports request a write. An operation that reads nothing and writes nothing completes without any handshake at all.

Top module: `cu_manager`

## Requirements
- R1: After reset, busyOut is low, every rdRel and wrRel bit is low, and aluInValid is low.
- R2: When issueIn is high while busyOut is low, the operation record (opType, opInvA, opImm, opImmOk, opZeroA, opRecCr) is captured. busyOut is high in the following cycle. The record inputs may change afterwards without effect on the operation.
- R3: Source port i raises rdRel[i] while it waits for its operand. srcData slice i (bits i*DATA_W upward) is captured in the cycle rdGo[i] is high, and rdRel[i] is low in the next cycle. Each needed source is granted exactly once per operation.
- R4: While rdSkip[i] is 1, source port i never raises rdRel[i], and its operand value is zero. The mask is read live and is not captured at issue.
- R5: With opZeroA set, source port 0 (A) is not requested and operand A is zero.
- R6: With opImmOk set, source port 1 (B) is not requested and operand B equals opImm.
- R7: Grants may arrive in any order, together, or after any delay. aluInValid rises only after all requested sources are captured, is accepted exactly once, and stays high with stable aluSrc while aluInReady is low.
- R8: aluOutReady is high while the operation executes, until aluOutValid is seen. A zero-latency unit that raises aluOutValid in the same cycle as the input acceptance is supported.
- R9: Result port j raises wrRel[j] only when aluResOk[j] was 1 with the captured result. During the wrGo[j] cycle, destData slice j holds that result and stays stable while any write is pending.
- R10: busyOut falls in the cycle after the last pending write is granted, and not before.
- R11: issueIn while busyOut is high is ignored: the operation in flight is unchanged and no second operation follows.
- R12: An operation with both sources skipped and no ok results, on a zero-latency unit, shows busyOut for exactly three cycles and raises no release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueIn | input | 1 | One-cycle issue strobe |
| opType | input | OP_W | Operation code |
| opInvA | input | 1 | Invert operand A (applied by the arithmetic unit) |
| opImm | input | DATA_W | Immediate value for operand B |
| opImmOk | input | 1 | Use opImm in place of source B |
| opZeroA | input | 1 | Use zero in place of source A |
| opRecCr | input | 1 | Record-condition flag passed to the arithmetic unit |
| busyOut | output | 1 | Operation in flight |
| rdSkip | input | N_SRC | Live per-source skip mask, 1 = skip |
| rdRel | output | N_SRC | Per-source operand request |
| rdGo | input | N_SRC | Per-source grant; data valid in this cycle |
| srcData | input | N_SRC*DATA_W | Source operands, port i at bits i*DATA_W |
| wrRel | output | N_DST | Per-result write request |
| wrGo | input | N_DST | Per-result write grant |
| destData | output | N_DST*DATA_W | Captured results, port j at bits j*DATA_W |
| aluInValid | output | 1 | Operands valid to the arithmetic unit |
| aluInReady | input | 1 | Arithmetic unit accepts operands |
| aluOpType | output | OP_W | Captured operation code |
| aluInvA | output | 1 | Captured invert-A flag |
| aluRecCr | output | 1 | Captured record-condition flag |
| aluSrc | output | N_SRC*DATA_W | Captured operands |
| aluOutValid | input | 1 | Arithmetic unit result valid |
| aluOutReady | output | 1 | Unit accepts the result |
| aluResult | input | N_DST*DATA_W | Arithmetic unit results |
| aluResOk | input | N_DST | Per-result write-enable from the arithmetic unit |

## Verification
A corrupted needed-source bit shows at the ports in the first read cycle, either as a release on a skipped port or as a missing release that stalls the unit with busy high. A wrong operand capture shows at the arithmetic unit input on the acceptance cycle, and again in the result read at the write grant. A fault in the state sequencing shows as busy falling before the last write grant, or as a second acceptance within one operation. The exact three-cycle busy window of the empty operation exposes any extra or missing state step.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_EXEC  = 2'd2,
    ST_WRITE = 2'd3
  } cuState_t;

  typedef struct packed {
    logic capOp;   // capture the operation record this cycle
    logic capRes;  // capture the arithmetic results this cycle
  } cuStrobe_t;

  localparam int SRC_A = 0;
  localparam int SRC_B = 1;
endpackage

// File: rtl/cu_ctrl.sv
module cu_ctrl
  import cu_pkg::*;
#(
  parameter int N_SRC = 2,
  parameter int N_DST = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issueIn,
  input  logic             opZeroA,
  input  logic             opImmOk,
  input  logic [N_SRC-1:0] rdSkip,
  input  logic [N_SRC-1:0] rdGo,
  input  logic             aluInReady,
  input  logic             aluOutValid,
  input  logic [N_DST-1:0] aluResOk,
  input  logic [N_DST-1:0] wrGo,
  output logic             busyOut,
  output logic [N_SRC-1:0] rdRel,
  output logic [N_SRC-1:0] rdTake,
  output logic             aluInValid,
  output logic             aluOutReady,
  output logic [N_DST-1:0] wrRel,
  output cuStrobe_t        strobe
);
  cuState_t         state;
  logic [N_SRC-1:0] needRd;
  logic [N_SRC-1:0] initNeed;
  logic [N_DST-1:0] wrPend;
  logic             sent;

  for (genvar i = 0; i < N_SRC; i++) begin : g_need
    if (i == SRC_A) begin : g_a
      assign initNeed[i] = ~opZeroA;
    end else if (i == SRC_B) begin : g_b
      assign initNeed[i] = ~opImmOk;
    end else begin : g_other
      assign initNeed[i] = 1'b1;
    end
  end

  always_comb begin
    busyOut       = (state != ST_IDLE);
    rdRel         = (state == ST_READ) ? (needRd & ~rdSkip) : '0;
    rdTake        = rdRel & rdGo;
    aluInValid    = (state == ST_EXEC) && !sent;
    aluOutReady   = (state == ST_EXEC);
    wrRel         = (state == ST_WRITE) ? wrPend : '0;
    strobe.capOp  = (state == ST_IDLE) && issueIn;
    strobe.capRes = (state == ST_EXEC) && aluOutValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      needRd <= '0;
      wrPend <= '0;
      sent   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (issueIn) begin
            needRd <= initNeed;
            sent   <= 1'b0;
            state  <= ST_READ;
          end
        end
        ST_READ: begin
          needRd <= needRd & ~rdTake;
          if ((rdRel & ~rdGo) == '0) state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (aluInValid && aluInReady) sent <= 1'b1;
          if (aluOutValid) begin
            wrPend <= aluResOk;
            state  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          wrPend <= wrPend & ~wrGo;
          if ((wrRel & ~wrGo) == '0) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cu_dpath.sv
module cu_dpath
  import cu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_SRC  = 2,
  parameter int N_DST  = 2,
  parameter int OP_W   = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  cuStrobe_t               strobe,
  input  logic [N_SRC-1:0]        rdTake,
  input  logic [OP_W-1:0]         opType,
  input  logic                    opInvA,
  input  logic [DATA_W-1:0]       opImm,
  input  logic                    opImmOk,
  input  logic                    opRecCr,
  input  logic [N_SRC*DATA_W-1:0] srcData,
  input  logic [N_DST*DATA_W-1:0] aluResult,
  output logic [N_SRC*DATA_W-1:0] aluSrc,
  output logic [OP_W-1:0]         aluOpType,
  output logic                    aluInvA,
  output logic                    aluRecCr,
  output logic [N_DST*DATA_W-1:0] destData
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_opnd
    logic [DATA_W-1:0] preset;
    if (i == SRC_B) begin : g_imm
      assign preset = opImmOk ? opImm : '0;
    end else begin : g_zero
      assign preset = '0;
    end
    always_ff @(posedge clk) begin
      if (rst)               aluSrc[i*DATA_W +: DATA_W] <= '0;
      else if (strobe.capOp) aluSrc[i*DATA_W +: DATA_W] <= preset;
      else if (rdTake[i])    aluSrc[i*DATA_W +: DATA_W] <= srcData[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aluOpType <= '0;
      aluInvA   <= 1'b0;
      aluRecCr  <= 1'b0;
      destData  <= '0;
    end else begin
      if (strobe.capOp) begin
        aluOpType <= opType;
        aluInvA   <= opInvA;
        aluRecCr  <= opRecCr;
      end
      if (strobe.capRes) destData <= aluResult;
    end
  end
endmodule

// File: rtl/cu_manager.sv
module cu_manager
  import cu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_SRC  = 2,
  parameter int N_DST  = 2,
  parameter int OP_W   = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issueIn,
  input  logic [OP_W-1:0]         opType,
  input  logic                    opInvA,
  input  logic [DATA_W-1:0]       opImm,
  input  logic                    opImmOk,
  input  logic                    opZeroA,
  input  logic                    opRecCr,
  output logic                    busyOut,
  input  logic [N_SRC-1:0]        rdSkip,
  output logic [N_SRC-1:0]        rdRel,
  input  logic [N_SRC-1:0]        rdGo,
  input  logic [N_SRC*DATA_W-1:0] srcData,
  output logic [N_DST-1:0]        wrRel,
  input  logic [N_DST-1:0]        wrGo,
  output logic [N_DST*DATA_W-1:0] destData,
  output logic                    aluInValid,
  input  logic                    aluInReady,
  output logic [OP_W-1:0]         aluOpType,
  output logic                    aluInvA,
  output logic                    aluRecCr,
  output logic [N_SRC*DATA_W-1:0] aluSrc,
  input  logic                    aluOutValid,
  output logic                    aluOutReady,
  input  logic [N_DST*DATA_W-1:0] aluResult,
  input  logic [N_DST-1:0]        aluResOk
);
  cuStrobe_t        strobe;
  logic [N_SRC-1:0] rdTake;

  cu_ctrl #(.N_SRC(N_SRC), .N_DST(N_DST)) u_ctrl (
    .clk(clk), .rst(rst), .issueIn(issueIn), .opZeroA(opZeroA), .opImmOk(opImmOk),
    .rdSkip(rdSkip), .rdGo(rdGo), .aluInReady(aluInReady), .aluOutValid(aluOutValid),
    .aluResOk(aluResOk), .wrGo(wrGo), .busyOut(busyOut), .rdRel(rdRel), .rdTake(rdTake),
    .aluInValid(aluInValid), .aluOutReady(aluOutReady), .wrRel(wrRel), .strobe(strobe)
  );

  cu_dpath #(.DATA_W(DATA_W), .N_SRC(N_SRC), .N_DST(N_DST), .OP_W(OP_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .rdTake(rdTake), .opType(opType),
    .opInvA(opInvA), .opImm(opImm), .opImmOk(opImmOk), .opRecCr(opRecCr),
    .srcData(srcData), .aluResult(aluResult), .aluSrc(aluSrc), .aluOpType(aluOpType),
    .aluInvA(aluInvA), .aluRecCr(aluRecCr), .destData(destData)
  );
endmodule

// File: rtl/cu_manager_chk.sv
module cu_manager_chk #(
  parameter int DATA_W = 16,
  parameter int N_SRC  = 2,
  parameter int N_DST  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    issueIn,
  input logic                    busyOut,
  input logic [N_SRC-1:0]        rdSkip,
  input logic [N_SRC-1:0]        rdRel,
  input logic [N_SRC-1:0]        rdGo,
  input logic [N_DST-1:0]        wrRel,
  input logic [N_DST-1:0]        wrGo,
  input logic [N_DST*DATA_W-1:0] destData,
  input logic                    aluInValid,
  input logic                    aluInReady,
  input logic [N_SRC*DATA_W-1:0] aluSrc
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busyOut |-> (rdRel == '0 && wrRel == '0 && !aluInValid)); // R1
  AST_BUSY_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (issueIn && !busyOut) |=> busyOut); // R2
  AST_REL_DROPS_AFTER_GO: assert property (@(posedge clk) disable iff (rst)
    ((rdRel & rdGo) != '0) |=> ((rdRel & $past(rdRel & rdGo)) == '0)); // R3
  AST_SKIP_NO_REL: assert property (@(posedge clk) disable iff (rst)
    ((rdRel & rdSkip) == '0)); // R4
  AST_ALU_HOLD: assert property (@(posedge clk) disable iff (rst)
    (aluInValid && !aluInReady) |=> (aluInValid && $stable(aluSrc))); // R7
  AST_NO_READ_DURING_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rdRel != '0) |-> (wrRel == '0 && !aluInValid)); // R7
  AST_DEST_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wrRel != '0) |=> (wrRel == '0 || $stable(destData))); // R9
  AST_BUSY_ENDS_AFTER_LAST_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrRel != '0 && (wrRel & ~wrGo) == '0) |=> !busyOut); // R10
endmodule

bind cu_manager cu_manager_chk #(.DATA_W(DATA_W), .N_SRC(N_SRC), .N_DST(N_DST)) u_chk (
  .clk(clk), .rst(rst), .issueIn(issueIn), .busyOut(busyOut), .rdSkip(rdSkip),
  .rdRel(rdRel), .rdGo(rdGo), .wrRel(wrRel), .wrGo(wrGo), .destData(destData),
  .aluInValid(aluInValid), .aluInReady(aluInReady), .aluSrc(aluSrc)
);

// File: tb/tb_cu_manager.sv
`timescale 1ns/1ps
module tb_cu_manager;
  localparam int W = 16;
  localparam int OW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          issueIn = 0, opInvA = 0, opImmOk = 0, opZeroA = 0, opRecCr = 0;
  logic [OW-1:0] opType = 0;
  logic [W-1:0]  opImm = 0;
  logic          busyOut;
  logic [1:0]    rdSkip = 0, rdRel, wrRel;
  logic          go0 = 0, go1 = 0, wgo0 = 0, wgo1 = 0;
  logic [W-1:0]  sv0 = 0, sv1 = 0;
  logic [2*W-1:0] destData, aluSrc, aluResult;
  logic          aluInValid, aluInReady = 1, aluOutValid, aluOutReady, aluInvA, aluRecCr;
  logic [OW-1:0] aluOpType;
  logic [1:0]    resOkV = 2'b11;

  cu_manager dut (
    .clk(clk), .rst(rst), .issueIn(issueIn), .opType(opType), .opInvA(opInvA),
    .opImm(opImm), .opImmOk(opImmOk), .opZeroA(opZeroA), .opRecCr(opRecCr),
    .busyOut(busyOut), .rdSkip(rdSkip), .rdRel(rdRel), .rdGo({go1, go0}),
    .srcData({sv1, sv0}), .wrRel(wrRel), .wrGo({wgo1, wgo0}), .destData(destData),
    .aluInValid(aluInValid), .aluInReady(aluInReady), .aluOpType(aluOpType),
    .aluInvA(aluInvA), .aluRecCr(aluRecCr), .aluSrc(aluSrc), .aluOutValid(aluOutValid),
    .aluOutReady(aluOutReady), .aluResult(aluResult), .aluResOk(resOkV)
  );

  // bench arithmetic unit: r0 = (invA ? ~a : a) + b, r1 = (a - b) ^ opType
  int           lat = 0;
  logic         pend = 0;
  int           cnt = 0;
  logic [2*W-1:0] held = 0;
  logic [W-1:0] seenA = 0, seenB = 0;
  logic [OW-1:0] seenOp = 0;
  int           acceptCnt = 0;

  function automatic logic [2*W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                           logic inv, logic [OW-1:0] op);
    logic [W-1:0] r0, r1;
    r0 = (inv ? ~a : a) + b;
    r1 = (a - b) ^ W'(op);
    return {r1, r0};
  endfunction

  wire accept = aluInValid && aluInReady;
  assign aluOutValid = (lat == 0) ? accept : (pend && cnt == 0);
  assign aluResult = (lat == 0) ? model(aluSrc[W-1:0], aluSrc[2*W-1:W], aluInvA, aluOpType) : held;

  always @(posedge clk) begin
    if (accept) begin
      seenA <= aluSrc[W-1:0];
      seenB <= aluSrc[2*W-1:W];
      seenOp <= aluOpType;
      acceptCnt <= acceptCnt + 1;
      if (lat != 0) begin
        held <= model(aluSrc[W-1:0], aluSrc[2*W-1:W], aluInvA, aluOpType);
        pend <= 1'b1;
        cnt <= lat - 1;
      end
    end else begin
      if (pend && cnt != 0) cnt <= cnt - 1;
      if (aluOutValid && aluOutReady && lat != 0) pend <= 1'b0;
    end
  end

  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  // source agents: wait for release, delay, grant for one cycle
  task automatic srcAgent(int port, int dly, logic [W-1:0] v, ref int grants);
    grants = 0;
    while (busyOut) begin
      if (rdRel[port]) begin
        repeat (dly) @(negedge clk);
        if (port == 0) begin go0 = 1; sv0 = v; end else begin go1 = 1; sv1 = v; end
        @(negedge clk);
        if (port == 0) begin go0 = 0; sv0 = 0; end else begin go1 = 0; sv1 = 0; end
        grants++;
        chk(!rdRel[port], "R3", "release low after grant", rdRel[port], 0);
      end else @(negedge clk);
    end
  endtask

  task automatic dstAgent(int port, int dly, logic [W-1:0] exp, ref int grants);
    grants = 0;
    while (busyOut) begin
      if (wrRel[port]) begin
        repeat (dly) @(negedge clk);
        if (port == 0) wgo0 = 1; else wgo1 = 1;
        chk(destData[port*W +: W] == exp, "R9", "result at write grant",
            destData[port*W +: W], exp);
        @(negedge clk);
        if (port == 0) wgo0 = 0; else wgo1 = 0;
        grants++;
      end else @(negedge clk);
    end
  endtask

  task automatic runOp(string name, logic [W-1:0] a, logic [W-1:0] b, logic inv,
                       logic zA, logic iOk, logic [W-1:0] imm, logic [OW-1:0] op,
                       logic [1:0] skip, logic [1:0] ok, int dA, int dB, int dW0, int dW1,
                       int latency, int stall, bit poke, int expBusy);
    logic [W-1:0] aE, bE;
    logic [2*W-1:0] r;
    int gA, gB, g0, g1, busyCnt, acc0;
    aE = (zA || skip[0]) ? '0 : a;
    bE = iOk ? imm : (skip[1] ? '0 : b);
    r = model(aE, bE, inv, op);
    acc0 = acceptCnt;
    @(negedge clk);
    chk(!busyOut, "R11", {name, " idle before issue"}, busyOut, 0);
    lat = latency; resOkV = ok; aluInReady = (stall == 0);
    opType = op; opInvA = inv; opZeroA = zA; opImmOk = iOk; opImm = imm; opRecCr = 1;
    rdSkip = skip; issueIn = 1;
    @(negedge clk);
    issueIn = 0; opType = 0; opInvA = 0; opZeroA = 0; opImmOk = 0; opImm = 0; opRecCr = 0;
    chk(busyOut, "R2", {name, " busy after issue"}, busyOut, 1);
    busyCnt = 0;
    fork
      srcAgent(0, dA, a, gA);
      srcAgent(1, dB, b, gB);
      dstAgent(0, dW0, r[W-1:0], g0);
      dstAgent(1, dW1, r[2*W-1:W], g1);
      begin
        while (busyOut) begin busyCnt++; @(negedge clk); end
      end
      begin
        if (stall != 0) begin
          while (busyOut && !aluInValid) @(negedge clk);
          repeat (stall) @(negedge clk);
          chk(aluInValid, "R7", {name, " valid held under stall"}, aluInValid, 1);
          aluInReady = 1;
        end
      end
      begin
        if (poke) begin
          @(negedge clk);
          issueIn = 1; opZeroA = 1; opImmOk = 1; opImm = 16'h7777; opType = 7'h55;
          @(negedge clk);
          issueIn = 0; opZeroA = 0; opImmOk = 0; opImm = 0; opType = 0;
        end
      end
    join
    rdSkip = 0;
    chk(gA == ((zA || skip[0]) ? 0 : 1), (zA ? "R5" : (skip[0] ? "R4" : "R3")),
        {name, " grants on A"}, gA, (zA || skip[0]) ? 0 : 1);
    chk(gB == ((iOk || skip[1]) ? 0 : 1), (iOk ? "R6" : (skip[1] ? "R4" : "R3")),
        {name, " grants on B"}, gB, (iOk || skip[1]) ? 0 : 1);
    chk(acceptCnt - acc0 == 1, "R7", {name, " one acceptance"}, acceptCnt - acc0, 1);
    chk(seenA == aE, "R7", {name, " operand A at acceptance"}, seenA, aE);
    chk(seenB == bE, "R6", {name, " operand B at acceptance"}, seenB, bE);
    chk(seenOp == op, "R2", {name, " captured op type"}, seenOp, op);
    chk(g0 == int'(ok[0]) && g1 == int'(ok[1]), "R9", {name, " write grants"},
        {g1[7:0], g0[7:0]}, {7'd0, ok[1], 7'd0, ok[0]});
    chk(!busyOut, "R10", {name, " busy low after last write"}, busyOut, 0);
    if (expBusy >= 0) chk(busyCnt == expBusy, "R12", {name, " busy cycles"}, busyCnt, expBusy);
    if (poke) begin
      @(negedge clk);
      chk(!busyOut && rdRel == 0, "R11", {name, " no second operation"}, busyOut, 0);
    end
  endtask

  task automatic tReset();
    chk(!busyOut, "R1", "busy after reset", busyOut, 0);
    chk(rdRel == 0 && wrRel == 0, "R1", "releases after reset", {rdRel, wrRel}, 0);
    chk(!aluInValid, "R1", "alu valid after reset", aluInValid, 0);
  endtask

  task automatic tBasic();    runOp("basic",   5, 2, 0, 0, 0, 0, 3,  2'b00, 2'b11, 0, 2, 0, 1, 2, 0, 0, -1); endtask
  task automatic tReorder();  runOp("reorder", 9, 4, 0, 0, 0, 0, 1,  2'b00, 2'b11, 3, 0, 2, 0, 1, 0, 0, -1); endtask
  task automatic tTogether(); runOp("together",21,7, 0, 0, 0, 0, 2,  2'b00, 2'b01, 1, 1, 1, 0, 0, 0, 0, -1); endtask  // R8 zero latency
  task automatic tZeroImm();  runOp("zeroimm", 5, 2, 0, 1, 1, 8, 4,  2'b00, 2'b01, 0, 0, 0, 0, 3, 0, 0, -1); endtask
  task automatic tImm();      runOp("imm",     5, 2, 0, 0, 1, 8, 6,  2'b00, 2'b10, 2, 0, 0, 2, 1, 0, 0, -1); endtask
  task automatic tInvStall(); runOp("invstall",5, 2, 1, 0, 0, 0, 9,  2'b00, 2'b11, 1, 2, 0, 0, 2, 3, 0, -1); endtask
  task automatic tZeroA();    runOp("zeroa",   5, 2, 1, 1, 0, 0, 0,  2'b00, 2'b11, 2, 0, 1, 1, 0, 0, 0, -1); endtask
  task automatic tSkipA();    runOp("skipa",   9, 2, 0, 0, 0, 0, 5,  2'b01, 2'b01, 2, 1, 2, 0, 1, 0, 0, -1); endtask
  task automatic tSkipB();    runOp("skipb",  16'h80, 3, 0, 0, 0, 0, 8, 2'b10, 2'b01, 2, 1, 0, 0, 2, 0, 0, -1); endtask
  task automatic tEmpty();    runOp("empty",   5, 2, 0, 0, 0, 0, 0,  2'b11, 2'b00, 1, 2, 1, 0, 0, 0, 0, 3); endtask
  task automatic tPoke();     runOp("poke",    7, 3, 0, 0, 0, 0, 11, 2'b00, 2'b11, 2, 2, 1, 1, 2, 0, 1, -1); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tReset();
    tBasic();
    tReorder();
    tTogether();
    tZeroImm();
    tImm();
    tInvStall();
    tZeroA();
    tSkipA();
    tSkipB();
    tEmpty();
    tPoke();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule